// File: doc/BRIEF.md
# I2C Master Command Sequencer

The sequencer sits between a transmit command FIFO and a bit-level I2C engine. It takes command words one at a time and breaks each into the byte-level operations the engine carries out: START, repeated START, STOP, write byte and read byte. Every START or repeated START is followed by an address byte. Bytes read from the bus are returned as receive entries, and the first byte after each address phase is marked.

Two bits in each command word set the framing. One asks for a STOP after the byte. The other asks for a repeated START before it. When repeated STARTs are disabled, a STOP followed by a new START takes the place of each repeated START. A command without STOP leaves the bus open. If no further command is waiting, the block holds the bus and flags a stall until one arrives. The block pulses an abort output and flushes the commands still waiting in two cases: a slave NACKs an address or data byte, or a read is requested toward the general-call target while the special flag is set.

Both edges use plain handshakes. Commands are popped with valid/ready. Each engine operation stays asserted until the engine returns a one-cycle done, which carries the slave's NACK and the byte that was read.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word holds data in bits 7:0, read select in bit 8 (1 = read), STOP request in bit 9 and repeated-START request in bit 10. Operation codes are 1 = START, 2 = repeated START, 3 = STOP, 4 = write byte, 5 = read byte. When the bus is idle, a command starts with START followed by the address write byte {target address, read bit}.
- R2: A write command produces one write-byte operation that carries bits 7:0 of the command.
- R3: A read command produces one read-byte operation, and its data bits have no effect. The receive entry holds the returned byte in bits 7:0. The master acknowledges (ack=1) unless the command also requests STOP, in which case it sends NACK (ack=0).
- R4: When bit 9 is set, a STOP follows the byte, and the next command opens a new transfer with START.
- R5: When bit 9 is clear and the next command keeps the same direction without a restart request, that command's byte follows directly, with no new START or address.
- R6: When bit 9 is clear and no command is waiting, stall_o is high, no operation is issued, and the bus stays held until a command arrives.
- R7: With repeated START enabled, a command with bit 10 set issues a repeated START and an address byte even when the direction is unchanged.
- R8: With repeated START enabled and bit 10 clear, a repeated START and an address byte are issued only when the direction differs from the previous command.
- R9: With repeated START disabled, every case that would issue a repeated START issues STOP and then START instead.
- R10: A read command with the general-call and special flags both set issues no operation for that command and pulses abort_o. When the general-call flag is set, the address byte is 0x00.
- R11: Bit 11 of a receive entry is 1 only for the first byte read after an address phase.
- R12: A NACK on an address or data write pulses abort_o one cycle after the done. All waiting commands are then popped without effect, and a STOP is issued if the bus is held.
- R13: While in reset, op_valid_o, rx_valid_o, abort_o and stall_o are low, and the first command after reset opens with START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command word is waiting |
| cmd_ready_o | output | 1 | Pops the waiting command |
| cmd_i | input | 11 | Command word |
| restart_en_i | input | 1 | Enables repeated START |
| tar_addr_i | input | 7 | Target address |
| tar_gc_i | input | 1 | Target is the general-call address |
| tar_special_i | input | 1 | Special flag for the general-call target |
| op_valid_o | output | 1 | Engine operation requested |
| op_code_o | output | 3 | Operation code |
| op_wdata_o | output | 8 | Byte to write |
| op_ack_o | output | 1 | Acknowledge to send after a read byte |
| op_done_i | input | 1 | Engine finished the operation |
| op_nack_i | input | 1 | Slave NACKed the written byte |
| op_rdata_i | input | 8 | Byte that was read |
| rx_valid_o | output | 1 | Receive entry is valid |
| rx_word_o | output | 12 | Receive entry, read byte in 7:0, first-byte flag in bit 11 |
| abort_o | output | 1 | One-cycle abort pulse |
| stall_o | output | 1 | Bus held waiting for a command |

## Verification
The bench uses the default 7-bit address. The command, data and receive widths follow from it, which keeps every field position of R1 and R11 fixed and visible. The engine model stretches each operation over a random 1 to 3 cycles and can NACK any chosen write. This reaches address and data NACKs anywhere in a list and drains that start at any point. A hold on the command stream makes the stall window of R6 long enough to observe.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_STOP   = 3'd3,
    OP_WRITE  = 3'd4,
    OP_READ   = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_FETCH,
    S_STOP_PRE,
    S_START,
    S_RSTART,
    S_ADDR,
    S_DATA,
    S_STOP_POST,
    S_DRAIN,
    S_STOP_ABORT
  } state_e;
endpackage

// File: rtl/i2c_seq_frame.sv
module i2c_seq_frame
  import i2c_seq_pkg::*;
(
  input  logic   active_i,
  input  logic   prev_rd_i,
  input  logic   rd_i,
  input  logic   restart_i,
  input  logic   restart_en_i,
  input  logic   gc_i,
  input  logic   special_i,
  output state_e nxt_o
);
  always_comb begin
    if (rd_i && gc_i && special_i)             nxt_o = S_DRAIN;
    else if (!active_i)                        nxt_o = S_START;
    else if (restart_i || (rd_i != prev_rd_i)) nxt_o = restart_en_i ? S_RSTART : S_STOP_PRE;
    else                                       nxt_o = S_DATA;
  end
endmodule

// File: rtl/i2c_seq_rx.sv
module i2c_seq_rx #(
  parameter int DATA_W = 8,
  parameter int RX_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [RX_W-1:0]   word_o
);
  localparam int PAD_W = RX_W - DATA_W - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= push_i;
      if (push_i) word_o <= {first_i, {PAD_W{1'b0}}, data_i};
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter  int ADDR_W = 7,
  localparam int DATA_W = ADDR_W + 1,
  localparam int CMD_W  = DATA_W + 3,
  localparam int RX_W   = DATA_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              restart_en_i,
  input  logic [ADDR_W-1:0] tar_addr_i,
  input  logic              tar_gc_i,
  input  logic              tar_special_i,
  output logic              op_valid_o,
  output logic [2:0]        op_code_o,
  output logic [DATA_W-1:0] op_wdata_o,
  output logic              op_ack_o,
  input  logic              op_done_i,
  input  logic              op_nack_i,
  input  logic [DATA_W-1:0] op_rdata_i,
  output logic              rx_valid_o,
  output logic [RX_W-1:0]   rx_word_o,
  output logic              abort_o,
  output logic              stall_o
);
  localparam int RD_B   = DATA_W;
  localparam int STOP_B = DATA_W + 1;
  localparam int RST_B  = DATA_W + 2;

  state_e            state_q, frame_nxt;
  logic [CMD_W-1:0]  cmd_q;
  logic              active_q, prev_rd_q, first_q, abort_q;
  logic              cur_rd, cur_stop, rx_push;
  logic [DATA_W-1:0] addr_byte;
  op_e               op;

  assign cur_rd    = cmd_q[RD_B];
  assign cur_stop  = cmd_q[STOP_B];
  assign addr_byte = tar_gc_i ? '0 : {tar_addr_i, cur_rd};

  i2c_seq_frame u_frame (
    .active_i     (active_q),
    .prev_rd_i    (prev_rd_q),
    .rd_i         (cmd_i[RD_B]),
    .restart_i    (cmd_i[RST_B]),
    .restart_en_i (restart_en_i),
    .gc_i         (tar_gc_i),
    .special_i    (tar_special_i),
    .nxt_o        (frame_nxt)
  );

  always_comb begin
    op         = OP_NONE;
    op_wdata_o = '0;
    op_ack_o   = 1'b0;
    unique case (state_q)
      S_STOP_PRE, S_STOP_POST, S_STOP_ABORT: op = OP_STOP;
      S_START:  op = OP_START;
      S_RSTART: op = OP_RSTART;
      S_ADDR: begin
        op         = OP_WRITE;
        op_wdata_o = addr_byte;
      end
      S_DATA: begin
        op         = cur_rd ? OP_READ : OP_WRITE;
        op_wdata_o = cur_rd ? '0 : cmd_q[DATA_W-1:0];
        op_ack_o   = cur_rd & ~cur_stop;  // NACK the last read before STOP
      end
      default: op = OP_NONE;
    endcase
  end

  assign op_valid_o  = (op != OP_NONE);
  assign op_code_o   = op;
  assign cmd_ready_o = (state_q == S_FETCH) || (state_q == S_DRAIN);
  assign stall_o     = (state_q == S_FETCH) && active_q && !cmd_valid_i;
  assign abort_o     = abort_q;
  assign rx_push     = (state_q == S_DATA) && op_done_i && cur_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_FETCH;
      cmd_q     <= '0;
      active_q  <= 1'b0;
      prev_rd_q <= 1'b0;
      first_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      unique case (state_q)
        S_FETCH: if (cmd_valid_i) begin
          cmd_q   <= cmd_i;
          state_q <= frame_nxt;
          if (frame_nxt == S_DRAIN) abort_q <= 1'b1;
        end
        S_STOP_PRE: if (op_done_i) state_q <= S_START;
        S_START, S_RSTART: if (op_done_i) begin
          active_q <= 1'b1;
          state_q  <= S_ADDR;
        end
        S_ADDR: if (op_done_i) begin
          if (op_nack_i) begin
            abort_q <= 1'b1;
            state_q <= S_DRAIN;
          end else begin
            first_q <= 1'b1;
            state_q <= S_DATA;
          end
        end
        S_DATA: if (op_done_i) begin
          if (!cur_rd && op_nack_i) begin
            abort_q <= 1'b1;
            state_q <= S_DRAIN;
          end else begin
            first_q   <= 1'b0;
            prev_rd_q <= cur_rd;
            state_q   <= cur_stop ? S_STOP_POST : S_FETCH;
          end
        end
        S_STOP_POST, S_STOP_ABORT: if (op_done_i) begin
          active_q <= 1'b0;
          state_q  <= S_FETCH;
        end
        S_DRAIN: if (!cmd_valid_i) state_q <= active_q ? S_STOP_ABORT : S_FETCH;
        default: state_q <= S_FETCH;
      endcase
    end
  end

  i2c_seq_rx #(.DATA_W(DATA_W), .RX_W(RX_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .first_i (first_q),
    .data_i  (op_rdata_i),
    .valid_o (rx_valid_o),
    .word_o  (rx_word_o)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       op_valid_o,
  input logic [2:0] op_code_o,
  input logic       op_ack_o,
  input logic       op_done_i,
  input logic       op_nack_i,
  input logic       rx_valid_o,
  input logic       abort_o,
  input logic       stall_o
);
  assert_op_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_done_i |=> op_valid_o && $stable(op_code_o));

  assert_rx_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(op_done_i && op_code_o == 3'd5));

  assert_nack_read_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_done_i && op_code_o == 3'd5 && !op_ack_o |=> op_valid_o && op_code_o == 3'd3);

  assert_stall_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !op_valid_o && cmd_ready_o);

  assert_write_nack_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_done_i && op_nack_i && op_code_o == 3'd4 |=> abort_o);

  assert_abort_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_pop_or_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && op_valid_o));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/sim_i2c_cmd_seq.sv
`timescale 1ns/1ps
module sim_i2c_cmd_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_ready_o;
  logic [10:0] cmd_i = '0;
  logic        restart_en_i = 1'b1, tar_gc_i = 1'b0, tar_special_i = 1'b0;
  logic [6:0]  tar_addr_i = 7'h2A;
  logic        op_valid_o, op_ack_o, op_done_i = 1'b0, op_nack_i = 1'b0;
  logic [2:0]  op_code_o;
  logic [7:0]  op_wdata_o, op_rdata_i = '0;
  logic        rx_valid_o, abort_o, stall_o;
  logic [11:0] rx_word_o;

  always #2.5 clk_i = ~clk_i;

  i2c_cmd_seq u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, gcyc = 0;
  logic [10:0] cmds [64];
  int ncmd, ptr, hold_idx, hold_until, nack_idx, nop, dly;
  bit pop_pend;
  logic [11:0] act_ops [256], exp_ops [256], act_rx [64], exp_rx [64];
  int n_act_ops, n_exp_ops, n_act_rx, n_exp_rx, n_act_ab, n_exp_ab;
  bit exp_stall;

  function automatic logic [7:0] rd_fn(int n);
    return 8'((n * 37 + 91) & 255);
  endfunction

  function automatic logic [10:0] mk(bit rs, bit st, bit rd, logic [7:0] d);
    return {rs, st, rd, d};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // engine, command feeder and monitors
  always @(negedge clk_i) begin
    gcyc++;
    if (!rst_ni) begin
      ptr = 0; pop_pend = 0; nop = 0; dly = 0; cyc = 0;
      n_act_ops = 0; n_act_rx = 0; n_act_ab = 0;
      cmd_valid_i = 0; op_done_i = 0; op_nack_i = 0;
    end else begin
      cyc++;
      if (pop_pend) ptr++;
      cmd_valid_i = (ptr < ncmd) && (ptr < hold_idx || cyc >= hold_until);
      cmd_i = cmds[ptr < 64 ? ptr : 0];
      pop_pend = cmd_valid_i && cmd_ready_o;
      if (op_done_i) begin
        op_done_i = 0; op_nack_i = 0;
      end else if (op_valid_o) begin
        if (dly == 0) begin
          act_ops[n_act_ops & 255] = {op_code_o, (op_code_o == 3'd5) ? op_ack_o : 1'b0,
                                      (op_code_o == 3'd4) ? op_wdata_o : 8'h00};
          n_act_ops++;
          op_done_i  = 1;
          op_nack_i  = (op_code_o == 3'd4) && (nop == nack_idx);
          op_rdata_i = rd_fn(nop);
          nop++;
          dly = $urandom % 3;
        end else dly--;
      end
      if (rx_valid_o) begin act_rx[n_act_rx & 63] = rx_word_o; n_act_rx++; end
      if (abort_o) n_act_ab++;
    end
  end

  task automatic push_op(logic [2:0] c, bit a, logic [7:0] d);
    exp_ops[n_exp_ops & 255] = {c, a, d};
    n_exp_ops++;
  endtask

  // reference model built from the requirements
  task automatic model();
    bit act = 0, prev = 0, first = 0, rd, st, rs;
    n_exp_ops = 0; n_exp_rx = 0; n_exp_ab = 0;
    for (int i = 0; i < ncmd; i++) begin
      rd = cmds[i][8]; st = cmds[i][9]; rs = cmds[i][10];
      if (rd && tar_gc_i && tar_special_i) begin                   // R10
        n_exp_ab++;
        if (act) begin push_op(3, 0, 0); act = 0; end
        break;
      end
      if (!act || rs || rd != prev) begin
        if (!act) push_op(1, 0, 0);
        else if (restart_en_i) push_op(2, 0, 0);                 // R7 R8
        else begin push_op(3, 0, 0); push_op(1, 0, 0); end       // R9
        act = 1;
        if (n_exp_ops == nack_idx) begin
          push_op(4, 0, tar_gc_i ? 8'h00 : {tar_addr_i, rd});
          n_exp_ab++; push_op(3, 0, 0); act = 0; break;          // R12
        end
        push_op(4, 0, tar_gc_i ? 8'h00 : {tar_addr_i, rd});
        first = 1;
      end
      if (rd) begin
        exp_rx[n_exp_rx & 63] = {first, 3'b000, rd_fn(n_exp_ops)};
        n_exp_rx++;
        push_op(5, !st, 0);                                      // R3
      end else begin
        if (n_exp_ops == nack_idx) begin
          push_op(4, 0, cmds[i][7:0]);
          n_exp_ab++; push_op(3, 0, 0); act = 0; break;
        end
        push_op(4, 0, cmds[i][7:0]);                             // R2
      end
      first = 0; prev = rd;
      if (st) begin push_op(3, 0, 0); act = 0; end               // R4
    end
    exp_stall = act;                                             // R6
  endtask

  task automatic run(string tag);
    int quiet = 0, t = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;
    while (quiet < 30 && t < 5000) begin
      @(negedge clk_i); #1;
      t++;
      if (ptr >= ncmd && !op_valid_o) quiet++; else quiet = 0;
    end
    if (t >= 5000) chk(0, {tag, " timeout"}, t, 0);
    model();
    chk(n_act_ops == n_exp_ops, {tag, " op count"}, n_act_ops, n_exp_ops);
    for (int i = 0; i < n_exp_ops && i < n_act_ops && i < 256; i++)
      chk(act_ops[i] === exp_ops[i], {tag, " op"}, act_ops[i], exp_ops[i]);
    chk(n_act_rx == n_exp_rx, {tag, " rx count R3"}, n_act_rx, n_exp_rx);
    for (int i = 0; i < n_exp_rx && i < n_act_rx && i < 64; i++)
      chk(act_rx[i] === exp_rx[i], {tag, " rx entry R11"}, act_rx[i], exp_rx[i]);
    chk(n_act_ab == n_exp_ab, {tag, " abort count R12"}, n_act_ab, n_exp_ab);
    chk(stall_o == exp_stall, {tag, " stall R6"}, stall_o, exp_stall);
  endtask

  task automatic setup(int n, bit ren, bit gc, bit sp, int nk);
    ncmd = n; restart_en_i = ren; tar_gc_i = gc; tar_special_i = sp;
    nack_idx = nk; hold_idx = 64; hold_until = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    setup(0, 1, 0, 0, -1);
    repeat (2) @(negedge clk_i); #1;
    chk(!op_valid_o && !rx_valid_o && !abort_o && !stall_o, "R13 reset outputs",
        {op_valid_o, rx_valid_o, abort_o, stall_o}, 0);

    setup(1, 1, 0, 0, -1); cmds[0] = mk(0, 1, 0, 8'h3C);
    run("R1 R2 R4 R13 single write");

    setup(3, 1, 0, 0, -1);
    cmds[0] = mk(0, 0, 1, 8'hFF); cmds[1] = mk(0, 0, 1, 8'h11); cmds[2] = mk(0, 1, 1, 8'h00);
    run("R3 R5 R11 read burst");

    setup(3, 1, 0, 0, -1);
    cmds[0] = mk(0, 0, 0, 8'h01); cmds[1] = mk(1, 0, 0, 8'h02); cmds[2] = mk(0, 1, 0, 8'h03);
    run("R7 forced restart");

    setup(3, 1, 0, 0, -1);
    cmds[0] = mk(0, 0, 0, 8'hA5); cmds[1] = mk(0, 0, 1, 8'hEE); cmds[2] = mk(0, 1, 1, 8'h77);
    run("R8 direction restart");

    setup(3, 0, 0, 0, -1);
    cmds[0] = mk(0, 0, 0, 8'hA5); cmds[1] = mk(1, 0, 1, 8'hEE); cmds[2] = mk(0, 1, 0, 8'h5A);
    run("R9 stop start fallback");

    setup(3, 1, 1, 1, -1);
    cmds[0] = mk(0, 0, 0, 8'h06); cmds[1] = mk(0, 0, 1, 8'h00); cmds[2] = mk(0, 1, 0, 8'h07);
    run("R10 general call read abort");

    setup(2, 1, 1, 0, -1);
    cmds[0] = mk(0, 0, 0, 8'h06); cmds[1] = mk(0, 1, 1, 8'h00);
    run("R10 special cleared");

    setup(3, 1, 0, 0, 1);
    cmds[0] = mk(0, 0, 0, 8'h10); cmds[1] = mk(0, 0, 0, 8'h20); cmds[2] = mk(0, 1, 0, 8'h30);
    run("R12 address nack");

    setup(3, 1, 0, 0, 3);
    cmds[0] = mk(0, 0, 0, 8'h10); cmds[1] = mk(0, 0, 0, 8'h20); cmds[2] = mk(0, 1, 0, 8'h30);
    run("R12 data nack");

    // R6: second command held back well past the first byte
    setup(2, 1, 0, 0, -1); hold_idx = 1; hold_until = 200;
    cmds[0] = mk(0, 0, 0, 8'h44); cmds[1] = mk(0, 1, 0, 8'h55);
    fork
      run("R6 stall then resume");
      begin
        wait (rst_ni);
        wait (cyc == 150);
        #1;
        chk(stall_o && !op_valid_o, "R6 stall during hold", {stall_o, op_valid_o}, 2);
      end
    join

    setup(2, 1, 0, 0, -1);
    cmds[0] = mk(0, 0, 0, 8'h44); cmds[1] = mk(0, 0, 1, 8'h55);
    run("R6 ends held");

    for (int k = 0; k < 30; k++) begin
      int n = 1 + ($urandom % 12);
      setup(n, $urandom % 2, 0, $urandom % 2, ($urandom % 3 == 0) ? int'($urandom % 30) : -1);
      for (int i = 0; i < n; i++) cmds[i] = 11'($urandom);
      run("random R1 R5 R7 R8 R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(negedge clk_i) if (gcyc > 190000) begin
    n_fail++;
    $display("FAIL watchdog act=%0d exp=0", gcyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule